// File: doc/BRIEF.md
# IPv4 Ingress Header Checker

This block sits in a router's receive datapath and inspects the start of each IPv4 packet, which arrives as a stream of 32-bit words marked with start and end strobes. A packet handed on by another processing engine of the same router may begin with a short internal header. The block strips that header and validates the IPv4 header. It then emits the header again with the time-to-live lowered by one and the header checksum patched to match.

When the last word of a packet has arrived, the block presents a 144-bit lookup key for the forwarding table. It presents the lookup-mode flags and the exception code next to the key, together with a drop verdict. Three saturating counters record the outcome of each packet: forwarded cleanly, dropped, or forwarded with an exception. The caller supplies a 32-bit router/interface tag with the first word, and a flag that says whether an internal header precedes the IPv4 header.

Top module: `ipv4_ingress_checker`

## Requirements
- R1: When `in_ihdr` is low on the start word, that word is IPv4 word 0. Each IPv4 word appears on `out_data` with `out_valid` in the cycle after it is accepted. `out_sop` marks word 0 and `out_eop` marks the word that carried `in_eop`.
- R2: When `in_ihdr` is high, the start word opens an internal header. Bits [31:24] hold its type and bits [23:16] hold its length L in bytes. That header fills ceil(L/4) words. None of those words is emitted, and IPv4 word 0 is the next word.
- R3: In IPv4 word 2, a nonzero TTL (bits [31:24]) leaves the block lowered by one. A zero TTL leaves unchanged. The checksum field (bits [15:0]) is patched incrementally, so that the rewritten header sums to 0xFFFF in one's-complement arithmetic.
- R4: Every IPv4 word other than word 2 is emitted bit for bit unchanged.
- R5: `res_valid` is high for exactly the one cycle after the end word is accepted. The other `res_*` outputs are valid in that cycle.
- R6: The key is laid out as follows: [143:112] the tag sampled with the start word, [111:80] the destination address (word 4), [79:48] the source address (word 3), [47:16] the transport word, [15:8] the protocol (word 2 bits [23:16]) and [7:0] the TCP flags.
- R7: The transport word is the first word after IHL header words. The TCP flags are bits [23:16] of the fourth word after the header, and are taken only when the protocol is 6. Either field is zero if the packet ends before that word.
- R8: Lookup flag bit 0 is set when an internal header of type 0x00 was present. Bit 1 is set when, in addition, L equals 10. In that case key [111:80] carries the second internal-header word instead of the destination address. Bits 3:2 are zero, and bit 1 is never set without bit 0.
- R9: Exception bit 0 is set when the arriving TTL is 0 or 1. Exception bit 1 is set when IHL is greater than 5. Exception bits 11:2 are zero.
- R10: `res_drop` is set when any of these holds:
  - the version is not 4;
  - IHL is below 5;
  - the total length is below 4×IHL;
  - fewer than IHL words arrived;
  - the one's-complement sum of the IHL header words is not 0xFFFF.
- R11: Each packet advances exactly one counter, in the cycle after `res_valid`. `cnt_drop` advances if the packet was dropped. Otherwise `cnt_exc` advances if any exception bit is set. Otherwise `cnt_pass` advances. A counter at its maximum stays there.
- R12: During and after reset, `out_valid` and `res_valid` are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 32 | Input word |
| in_ihdr | input | 1 | Internal header precedes IPv4, sampled with the start word |
| in_tag | input | 32 | Router/interface tag, sampled with the start word |
| out_valid | output | 1 | Rewritten header word present |
| out_sop | output | 1 | Output word is IPv4 word 0 |
| out_eop | output | 1 | Output word is the packet's last |
| out_data | output | 32 | Rewritten word |
| res_valid | output | 1 | Result strobe |
| res_key | output | 144 | Lookup key |
| res_lflags | output | 4 | Lookup mode flags |
| res_exc | output | 12 | Exception code bits |
| res_drop | output | 1 | Packet must be discarded |
| cnt_pass | output | CNT_W | Clean packets |
| cnt_drop | output | CNT_W | Dropped packets |
| cnt_exc | output | CNT_W | Packets forwarded with an exception |

## Verification
Each rewritten word is due one clock after the edge that accepts it. The key, flags, exception bits and drop verdict are due one clock after the end word, and the counters one clock after that. The bench drives inputs on falling edges. At each falling edge it first inspects the outputs produced by the word sent one edge earlier. On the edge after the last word it reads the results, and one edge later it reads the counters. It sweeps every TTL value under two protocols, then varies the option length, the internal-header type and length, and the malformed-header cases. Expected results are derived arithmetically from the words it built.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 144;
  localparam int LF_W   = 4;
  localparam int EXC_W  = 12;

  localparam logic [7:0] IH_FWDKEY = 8'h00;
  localparam logic [7:0] IH_LEN_NH = 8'd10;
  localparam logic [7:0] PROTO_TCP = 8'd6;

  // 16-bit one's-complement add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] word_fold(input logic [WORD_W-1:0] w);
    return oc_add(w[31:16], w[15:0]);
  endfunction

  // incremental checksum patch: ~(~hc + ~old + new)
  function automatic logic [15:0] cksum_patch(input logic [15:0] hc,
                                              input logic [15:0] m_old,
                                              input logic [15:0] m_new);
    return ~oc_add(oc_add(~hc, ~m_old), m_new);
  endfunction

  // rewrite of the TTL/protocol/checksum word
  function automatic logic [WORD_W-1:0] ttl_rewrite(input logic [WORD_W-1:0] w);
    logic [15:0] m_new;
    if (w[31:24] == 8'd0) return w;
    m_new = {w[31:24] - 8'd1, w[23:16]};
    return {m_new, cksum_patch(w[15:0], w[31:16], m_new)};
  endfunction
endpackage

// File: rtl/ihc_rewrite.sv
module ihc_rewrite import ihc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_is_ttl,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] word_nx;
  assign word_nx = in_is_ttl ? ttl_rewrite(in_word) : in_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_fire;
      out_sop   <= in_fire & in_first;
      out_eop   <= in_fire & in_last;
      if (in_fire) out_data <= word_nx;
    end
  end

  a_r3_ttl_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_is_ttl && in_word[31:24] != 8'd0) |=>
      (out_valid && out_data[31:24] == $past(in_word[31:24]) - 8'd1));

  a_r4_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !in_is_ttl) |=> (out_valid && out_data == $past(in_word)));
endmodule

// File: rtl/ihc_stats.sv
module ihc_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic             drop,
  input  logic             exc_any,
  output logic [CNT_W-1:0] cnt_pass,
  output logic [CNT_W-1:0] cnt_drop,
  output logic [CNT_W-1:0] cnt_exc
);
  localparam int NCLS = 3;
  localparam int C_PASS = 0;
  localparam int C_DROP = 1;
  localparam int C_EXC  = 2;

  logic [NCLS-1:0]            hit;
  logic [NCLS-1:0][CNT_W-1:0] cnt_q;

  assign hit[C_PASS] = fin & ~drop & ~exc_any;
  assign hit[C_DROP] = fin &  drop;
  assign hit[C_EXC]  = fin & ~drop &  exc_any;

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                  q <= '0;
      else if (hit[g] && q != '1)  q <= q + CNT_W'(1);
    end
    assign cnt_q[g] = q;
  end

  assign cnt_pass = cnt_q[C_PASS];
  assign cnt_drop = cnt_q[C_DROP];
  assign cnt_exc  = cnt_q[C_EXC];

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(cnt_q));

  a_r11_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && drop && cnt_q[C_DROP] != '1) |=> cnt_q[C_DROP] == $past(cnt_q[C_DROP]) + CNT_W'(1));
endmodule

// File: rtl/ipv4_ingress_checker.sv
module ipv4_ingress_checker import ihc_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_ihdr,
  input  logic [WORD_W-1:0] in_tag,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [WORD_W-1:0] out_data,
  output logic              res_valid,
  output logic [KEY_W-1:0]  res_key,
  output logic [LF_W-1:0]   res_lflags,
  output logic [EXC_W-1:0]  res_exc,
  output logic              res_drop,
  output logic [CNT_W-1:0]  cnt_pass,
  output logic [CNT_W-1:0]  cnt_drop,
  output logic [CNT_W-1:0]  cnt_exc
);
  localparam int SKIP_W = 7;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  // sequencing state
  logic [SKIP_W-1:0] skip_left;
  logic [1:0]        ih_pos;
  logic [IDX_W-1:0]  wi;
  logic              fin_q;
  // captured fields
  logic [WORD_W-1:0] tag_q, nh_q, sa_q, da_q, ports_q;
  logic              has_ih_q;
  logic [7:0]        ih_type_q, ih_len_q, ttl_q, proto_q, tflags_q;
  logic [3:0]        ver_q, ihl_q;
  logic [15:0]       tlen_q, acc_q;

  // internal events, named for the checks
  logic              is_ih_word, is_ip_word;
  logic [IDX_W-1:0]  idx;
  logic [3:0]        ihl_cur;
  logic [SKIP_W-1:0] ih_words;
  logic [15:0]       word_sum;

  assign is_ih_word = in_valid & (in_sop ? in_ihdr : (skip_left != '0));
  assign is_ip_word = in_valid & ~is_ih_word;
  assign idx        = in_sop ? '0 : wi;
  assign ihl_cur    = (idx == '0) ? in_data[27:24] : ihl_q;
  assign ih_words   = SKIP_W'(({1'b0, in_data[23:16]} + 9'd3) >> 2);
  assign word_sum   = word_fold(in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_left <= '0; ih_pos <= '0; wi <= '0; fin_q <= 1'b0;
      tag_q <= '0; nh_q <= '0; sa_q <= '0; da_q <= '0; ports_q <= '0;
      has_ih_q <= 1'b0; ih_type_q <= '0; ih_len_q <= '0;
      ttl_q <= '0; proto_q <= '0; tflags_q <= '0;
      ver_q <= '0; ihl_q <= '0; tlen_q <= '0; acc_q <= '0;
    end else begin
      fin_q <= in_valid & in_eop;
      if (in_valid && in_sop) begin
        tag_q <= in_tag; has_ih_q <= in_ihdr;
        ih_type_q <= '0; ih_len_q <= '0; nh_q <= '0;
        skip_left <= '0; ih_pos <= '0; wi <= '0;
        sa_q <= '0; da_q <= '0; ports_q <= '0;
        ttl_q <= '0; proto_q <= '0; tflags_q <= '0;
        ver_q <= '0; ihl_q <= '0; tlen_q <= '0; acc_q <= '0;
      end
      if (is_ih_word) begin
        if (in_sop) begin
          ih_type_q <= in_data[31:24];
          ih_len_q  <= in_data[23:16];
          skip_left <= (ih_words == '0) ? '0 : ih_words - SKIP_W'(1);
          ih_pos    <= 2'd1;
        end else begin
          skip_left <= skip_left - SKIP_W'(1);
          if (ih_pos == 2'd1) nh_q <= in_data;
          if (ih_pos != 2'd3) ih_pos <= ih_pos + 2'd1;
        end
      end else if (is_ip_word) begin
        if (idx != IDX_MAX) wi <= idx + IDX_W'(1);
        if (idx == IDX_W'(0)) begin
          ver_q <= in_data[31:28]; ihl_q <= in_data[27:24]; tlen_q <= in_data[15:0];
        end
        if (idx == IDX_W'(2)) begin ttl_q <= in_data[31:24]; proto_q <= in_data[23:16]; end
        if (idx == IDX_W'(3)) sa_q <= in_data;
        if (idx == IDX_W'(4)) da_q <= in_data;
        if (idx == IDX_W'(ihl_cur)) ports_q <= in_data;
        if (idx == IDX_W'(ihl_cur) + IDX_W'(3) && proto_q == PROTO_TCP)
          tflags_q <= in_data[23:16];
        if (idx == IDX_W'(0))             acc_q <= word_sum;
        else if (idx < IDX_W'(ihl_cur))   acc_q <= oc_add(acc_q, word_sum);
      end
    end
  end

  // verdict, presented while fin_q is high
  logic lf0, lf1, bad_len, trunc;
  assign lf0     = has_ih_q & (ih_type_q == IH_FWDKEY);
  assign lf1     = lf0 & (ih_len_q == IH_LEN_NH);
  assign bad_len = tlen_q < {10'd0, ihl_q, 2'b00};
  assign trunc   = wi < IDX_W'(ihl_q);

  assign res_valid  = fin_q;
  assign res_drop   = (ver_q != 4'd4) | (ihl_q < 4'd5) | bad_len | trunc | (acc_q != 16'hFFFF);
  assign res_exc    = {{(EXC_W-2){1'b0}}, ihl_q > 4'd5, ttl_q <= 8'd1};
  assign res_lflags = {{(LF_W-2){1'b0}}, lf1, lf0};
  assign res_key    = {tag_q, lf1 ? nh_q : da_q, sa_q, ports_q, proto_q, tflags_q};

  ihc_rewrite u_rw (
    .clk(clk), .rst_n(rst_n),
    .in_fire(is_ip_word), .in_first(idx == IDX_W'(0)), .in_last(in_eop),
    .in_is_ttl(idx == IDX_W'(2)), .in_word(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  ihc_stats #(.CNT_W(CNT_W)) u_st (
    .clk(clk), .rst_n(rst_n),
    .fin(fin_q), .drop(res_drop), .exc_any(res_exc != '0),
    .cnt_pass(cnt_pass), .cnt_drop(cnt_drop), .cnt_exc(cnt_exc)
  );

  a_r5_res_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop) |=> res_valid);

  a_r5_res_only_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eop));

  a_r2_ih_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    is_ih_word |=> !out_valid);

  a_r8_flag_order: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_lflags[1] && !res_lflags[0]));
endmodule

// File: tb/sim_ipv4_ingress_checker.sv
module sim_ipv4_ingress_checker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_sop, in_eop, in_ihdr;
  logic [31:0] in_data, in_tag, out_data;
  logic out_valid, out_sop, out_eop, res_valid, res_drop;
  logic [143:0] res_key;
  logic [3:0] res_lflags;
  logic [11:0] res_exc;
  logic [15:0] cnt_pass, cnt_drop, cnt_exc;

  ipv4_ingress_checker u0 (.*);

  int checks = 0, fails = 0;
  int e_pass = 0, e_drop = 0, e_exc = 0;
  bit done = 1'b0;
  logic [31:0] pw [0:31];
  logic [31:0] gw [0:31];
  logic [31:0] ihw [0:3];
  int np = 0, nih = 0;

  task automatic chk(input string rq, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] ones_sum(input logic [31:0] a [0:31], input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += int'(a[i][31:16]) + int'(a[i][15:0]);
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >>> 16);
    return s[15:0];
  endfunction

  task automatic mk_ip(input logic [3:0] ver, input int ihl, input logic [15:0] tlen,
                       input logic [7:0] ttl, input logic [7:0] proto, input logic [31:0] sa,
                       input logic [31:0] da, input logic [31:0] ports, input logic [7:0] tfl,
                       input int ntail);
    int hw = (ihl < 5) ? 5 : ihl;
    pw[0] = {ver, 4'(ihl), 8'h00, tlen};
    pw[1] = 32'h1234_4000;
    pw[2] = {ttl, proto, 16'h0000};
    pw[3] = sa;
    pw[4] = da;
    for (int i = 5; i < hw; i++) pw[i] = 32'h0101_0100 + i;
    pw[hw] = ports; pw[hw+1] = 32'hA5A5_0001; pw[hw+2] = 32'h0;
    pw[hw+3] = {8'h50, tfl, 16'hFFFF};
    pw[2][15:0] = ~ones_sum(pw, hw);
    np = hw + ntail;
  endtask

  task automatic mk_ih(input logic [7:0] typ, input logic [7:0] len, input logic [31:0] nh);
    nih = (int'(len) + 3) / 4;
    ihw[0] = {typ, len, 16'h0042};
    ihw[1] = nh;
    ihw[2] = 32'hBEEF_0000;
    ihw[3] = 32'h0;
  endtask

  task automatic look_out(input int k);
    int j;
    if (k < nih) begin
      chk("R2 internal word hidden", 144'(out_valid), 144'(0));
    end else begin
      j = k - nih;
      gw[j] = out_data;
      chk("R1 out_valid", 144'(out_valid), 144'(1));
      chk("R1 out_sop", 144'(out_sop), 144'(j == 0));
      chk("R1 out_eop", 144'(out_eop), 144'(j == np - 1));
      if (j == 2)
        chk("R3 ttl word", 144'(out_data[31:16]),
            144'({(pw[2][31:24] == 0) ? 8'd0 : pw[2][31:24] - 8'd1, pw[2][23:16]}));
      else
        chk("R4 word unchanged", 144'(out_data), 144'(pw[j]));
    end
  endtask

  task automatic run_pkt(input logic [31:0] tag);
    int total = nih + np;
    int ihl = int'(pw[0][27:24]);
    logic [7:0] ttl = (np > 2) ? pw[2][31:24] : 8'd0;
    logic [7:0] proto = (np > 2) ? pw[2][23:16] : 8'd0;
    logic lf0 = (nih > 0) && ihw[0][31:24] == 8'h00;
    logic lf1 = lf0 && ihw[0][23:16] == 8'd10;
    logic [11:0] e_x = {10'd0, ihl > 5, ttl <= 8'd1};
    logic e_d;
    logic [31:0] ports = (np > ihl) ? pw[ihl] : 32'h0;
    logic [7:0] tfl = (proto == 8'd6 && np > ihl + 3) ? pw[ihl+3][23:16] : 8'd0;
    logic [143:0] e_key;
    e_d = pw[0][31:28] != 4'd4 || ihl < 5 || int'(pw[0][15:0]) < 4 * ihl || np < ihl
          || ones_sum(pw, ihl) != 16'hFFFF;
    e_key = {tag, lf1 ? ihw[1] : ((np > 4) ? pw[4] : 32'h0), (np > 3) ? pw[3] : 32'h0,
             ports, proto, tfl};
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k > 0) look_out(k - 1);
      in_valid = 1'b1; in_sop = (k == 0); in_eop = (k == total - 1);
      in_ihdr = (nih > 0); in_tag = tag;
      in_data = (k < nih) ? ihw[k] : pw[k - nih];
    end
    @(negedge clk);
    look_out(total - 1);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    chk("R5 res_valid", 144'(res_valid), 144'(1));
    chk("R10 drop", 144'(res_drop), 144'(e_d));
    chk("R9 exception bits", 144'(res_exc), 144'(e_x));
    chk("R8 lookup flags", 144'(res_lflags), 144'({lf1, lf0}));
    if (!e_d) begin
      chk("R6 R7 key", res_key, e_key);
      chk("R3 checksum verifies", 144'(ones_sum(gw, ihl)), 144'(16'hFFFF));
    end
    if (e_d) e_drop++; else if (e_x != 0) e_exc++; else e_pass++;
    @(negedge clk);
    chk("R5 res pulse ends", 144'(res_valid), 144'(0));
    chk("R11 pass count", 144'(cnt_pass), 144'(e_pass));
    chk("R11 drop count", 144'(cnt_drop), 144'(e_drop));
    chk("R11 exc count", 144'(cnt_exc), 144'(e_exc));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_ihdr = 1'b0; in_data = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", 144'(out_valid), 144'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 res_valid after reset", 144'(res_valid), 144'(0));
    chk("R12 counters zero", 144'({cnt_pass, cnt_drop, cnt_exc}), 144'(0));

    // R3 R9: every TTL value, TCP and UDP alternately
    nih = 0;
    for (int t = 0; t < 256; t++) begin
      mk_ip(4'd4, 5, 16'd60, 8'(t), (t % 2 == 1) ? 8'd6 : 8'd17, 32'h0A00_0001 + t,
            32'hC0A8_0000 + (t * 7), 32'h1F90_0050 + t, 8'(t * 3), 4);
      run_pkt(32'hC000_0000 + t);
    end
    // R9: option words
    for (int h = 6; h <= 8; h++) begin
      mk_ip(4'd4, h, 16'd80, 8'd64, 8'd6, 32'h0B0B_0B0B, 32'h0C0C_0C0C, 32'h0400_0500, 8'h12, 4);
      run_pkt(32'h0000_1111 * h);
    end
    // R7: transport words missing or partial
    mk_ip(4'd4, 5, 16'd40, 8'd9, 8'd6, 32'h1, 32'h2, 32'h3, 8'h18, 0); run_pkt(32'h77);
    mk_ip(4'd4, 5, 16'd40, 8'd9, 8'd6, 32'h1, 32'h2, 32'h3, 8'h18, 2); run_pkt(32'h78);
    // R2 R8: internal header types and lengths
    for (int ty = 0; ty < 3; ty++) begin
      for (int ln = 6; ln <= 10; ln += 2) begin
        mk_ih((ty == 0) ? 8'h00 : ((ty == 1) ? 8'h01 : 8'h05), 8'(ln), 32'hFEED_0000 + ln);
        mk_ip(4'd4, 5, 16'd52, 8'd30, 8'd6, 32'hAB00_0000 + ln, 32'hCD00_0000 + ty,
              32'h0016_0400, 8'h02, 4);
        run_pkt(32'h5000_0000 + ty * 16 + ln);
      end
    end
    nih = 0;
    // R10: malformed headers
    mk_ip(4'd6, 5, 16'd40, 8'd20, 8'd6, 32'h1, 32'h2, 32'h3, 8'h0, 4); run_pkt(32'h91);
    mk_ip(4'd4, 4, 16'd40, 8'd20, 8'd6, 32'h1, 32'h2, 32'h3, 8'h0, 4); run_pkt(32'h92);
    mk_ip(4'd4, 5, 16'd16, 8'd20, 8'd6, 32'h1, 32'h2, 32'h3, 8'h0, 4); run_pkt(32'h93);
    mk_ip(4'd4, 5, 16'd40, 8'd20, 8'd6, 32'h1, 32'h2, 32'h3, 8'h0, 4);
    pw[2][0] = ~pw[2][0]; run_pkt(32'h94);
    mk_ip(4'd4, 5, 16'd40, 8'd20, 8'd6, 32'h1, 32'h2, 32'h3, 8'h0, 0);
    np = 3; run_pkt(32'h95);
    mk_ih(8'h00, 8'd10, 32'h1234_5678);
    mk_ip(4'd4, 7, 16'd40, 8'd20, 8'd17, 32'h1, 32'h2, 32'h3, 8'h0, 4);
    np = 6; run_pkt(32'h96);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule